// File: doc/BRIEF.md
# ADC Result Byte Port

This block places a 17-bit conversion result on an 8-bit microprocessor data bus. The result has 15 magnitude bits, a sign bit (high means a positive input) and an overrange flag (high means the input is beyond full scale). When the input is above full scale, the low byte holds the excess count. A sequencer supplies the result and a busy signal. The falling edge of busy marks a finished conversion, and on that edge the block captures the result.

Selection works like a memory device. An active-high select and an active-low enable are ANDed together to qualify both the read and write strobes. In on-demand mode, software picks the byte with a high/low select and chooses what bit 7 of the high byte carries with a flag/sign select. A write strobe requests a new conversion. In continuous mode, both selects are ignored and a fixed three-byte sequence is read:
1. high byte with the sign bit,
2. low byte,
3. high byte with the overrange flag.

Each read rising edge advances an internal pointer. The data is lost if it is not collected within a fixed number of clocks.

Top module: `adc_result_port`

## Requirements
- R1: The bus is driven (`db_oe`=1) only while `cs`=1, `ce_n`=0 and `rd_n`=0. Otherwise `db_oe`=0 and `db_out`=8'h00.
- R2: In on-demand mode (`cont_mode`=0) with `sel_high`=0, a read returns magnitude bits 7..0.
- R3: In on-demand mode with `sel_high`=1, a read returns magnitude bits 14..8 on bits 6..0. Bit 7 is the overrange flag when `ovr_sel`=1 and the sign bit when `ovr_sel`=0.
- R4: In continuous mode (`cont_mode`=1), the byte returned depends only on the pointer, and `sel_high` and `ovr_sel` have no effect. Position 0 gives {sign, mag[14:8]}, position 1 gives mag[7:0], and position 2 gives {overrange, mag[14:8]}.
- R5: In continuous mode, the pointer advances by one on each `rd_n` rising edge seen while selected, and wraps from position 2 back to 0. A rising edge while deselected does not move it.
- R6: On a `busy` falling edge, the result inputs are captured and the pointer returns to position 0. The new data is readable from the next clock.
- R7: In continuous mode, the captured data stays readable for WINDOW-1 clocks after the capture edge. On the WINDOW-th clock, the data is cleared to zero and the pointer returns to position 0.
- R8: In on-demand mode, the captured data is held without time limit until the next capture, and can be read any number of times in any order.
- R9: `conv_start` pulses high for exactly one clock, in the clock after a falling edge of `wr_n` seen while selected in on-demand mode. It does not pulse in continuous mode, while deselected, or while `wr_n` is held low.
- R10: After reset, the captured data is zero, the pointer is at position 0 and `conv_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select, active high |
| ce_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write (start) strobe, active low |
| sel_high | input | 1 | On-demand byte select: 1 = high byte |
| ovr_sel | input | 1 | On-demand bit-7 select: 1 = overrange, 0 = sign |
| cont_mode | input | 1 | 1 = continuous sequence, 0 = on-demand |
| busy | input | 1 | Conversion busy from sequencer; falling edge captures |
| res_mag | input | MAG_W | Result magnitude |
| res_pol | input | 1 | Result sign, 1 = positive |
| res_ovr | input | 1 | Result overrange flag |
| db_out | output | 8 | Data bus value |
| db_oe | output | 1 | Data bus drive enable |
| conv_start | output | 1 | One-clock conversion request |

## Verification
Some properties are checked on every cycle by assertions:
- the bus stays quiet whenever it is not enabled,
- the pointer never reaches an unused position and rewinds on every capture,
- on-demand data never changes between captures,
- the expiry clears the data,
- the start request is a single clock long and only ever follows an on-demand cycle.

Other behaviour only the bench scenarios can show:
- which byte and which bit-7 source a given select combination produces,
- the exact order of the three continuous bytes and the wrap after the third,
- that deselected read edges are ignored,
- the precise clock on which the read window closes.

// File: rtl/adc_result_port.sv
module adc_result_port #(
  parameter int MAG_W  = 15,
  parameter int WINDOW = 444
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             ce_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             sel_high,
  input  logic             ovr_sel,
  input  logic             cont_mode,
  input  logic             busy,
  input  logic [MAG_W-1:0] res_mag,
  input  logic             res_pol,
  input  logic             res_ovr,
  output logic [7:0]       db_out,
  output logic             db_oe,
  output logic             conv_start
);
  localparam int TW = $clog2(WINDOW + 1);
  localparam logic [TW-1:0] LAST = TW'(WINDOW - 1);

  logic [MAG_W-1:0] mag_q;
  logic             pol_q, ovr_q;
  logic             rd_q, wr_q, busy_q;
  logic [1:0]       pos;
  logic [TW-1:0]    tmr;
  logic             live;
  logic [7:0]       mux;

  wire sel     = cs & ~ce_n;
  wire capture = busy_q & ~busy;
  wire rd_rise = sel & ~rd_q & rd_n;
  wire expire  = cont_mode & live & (tmr == LAST);
  wire [6:0] hi7 = 7'(mag_q >> 8);
  wire [7:0] lo8 = mag_q[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q      <= '0;
      pol_q      <= 1'b0;
      ovr_q      <= 1'b0;
      rd_q       <= 1'b1;
      wr_q       <= 1'b1;
      busy_q     <= 1'b0;
      pos        <= 2'd0;
      tmr        <= '0;
      live       <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      rd_q       <= rd_n;
      wr_q       <= wr_n;
      busy_q     <= busy;
      conv_start <= sel & ~cont_mode & wr_q & ~wr_n;
      if (capture) begin
        mag_q <= res_mag;
        pol_q <= res_pol;
        ovr_q <= res_ovr;
        pos   <= 2'd0;
        tmr   <= '0;
        live  <= 1'b1;
      end else if (expire) begin
        mag_q <= '0;
        pol_q <= 1'b0;
        ovr_q <= 1'b0;
        pos   <= 2'd0;
        live  <= 1'b0;
      end else begin
        if (cont_mode && live) tmr <= tmr + 1'b1;
        if (cont_mode && rd_rise) pos <= (pos == 2'd2) ? 2'd0 : pos + 2'd1;
      end
    end
  end

  always_comb begin
    if (cont_mode) begin
      case (pos)
        2'd0:    mux = {pol_q, hi7};
        2'd1:    mux = lo8;
        default: mux = {ovr_q, hi7};
      endcase
    end else if (sel_high) begin
      mux = {ovr_sel ? ovr_q : pol_q, hi7};
    end else begin
      mux = lo8;
    end
  end

  assign db_oe  = sel & ~rd_n;
  assign db_out = db_oe ? mux : 8'h00;

endmodule

// File: rtl/adc_result_port_chk.sv
module adc_result_port_chk #(
  parameter int MAG_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cont_mode,
  input logic             busy,
  input logic             busy_q,
  input logic [7:0]       db_out,
  input logic             db_oe,
  input logic             conv_start,
  input logic [1:0]       pos,
  input logic             live,
  input logic [MAG_W-1:0] mag_q,
  input logic             pol_q,
  input logic             ovr_q
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !db_oe |-> db_out == 8'h00); // R1
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos != 2'd3); // R5
  AST_CAPTURE_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !busy) |=> pos == 2'd0); // R6
  AST_EXPIRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(live) |-> (mag_q == '0 && !pol_q && !ovr_q && pos == 2'd0)); // R7
  AST_DEMAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_mode && !(busy_q && !busy)) |=> ($stable(mag_q) && $stable(pol_q) && $stable(ovr_q))); // R8
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R9
  AST_START_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !$past(cont_mode)); // R9
endmodule

bind adc_result_port adc_result_port_chk #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cont_mode(cont_mode), .busy(busy), .busy_q(busy_q),
  .db_out(db_out), .db_oe(db_oe), .conv_start(conv_start), .pos(pos),
  .live(live), .mag_q(mag_q), .pol_q(pol_q), .ovr_q(ovr_q)
);

// File: tb/tb_adc_result_port.sv
module tb_adc_result_port;
  localparam int CLK_P  = 10;
  localparam int WINDOW = 444;

  logic clk = 0, rst_n = 0;
  logic cs = 0, ce_n = 1, rd_n = 1, wr_n = 1, sel_high = 0, ovr_sel = 0, cont_mode = 0, busy = 0;
  logic [14:0] res_mag = '0;
  logic res_pol = 0, res_ovr = 0;
  logic [7:0] db_out;
  logic db_oe, conv_start;

  int total = 0, bad = 0;
  logic [14:0] m_mag = '0;
  logic m_pol = 0, m_ovr = 0;
  int m_pos = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_result_port #(.MAG_W(15), .WINDOW(WINDOW)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
    .sel_high(sel_high), .ovr_sel(ovr_sel), .cont_mode(cont_mode), .busy(busy),
    .res_mag(res_mag), .res_pol(res_pol), .res_ovr(res_ovr),
    .db_out(db_out), .db_oe(db_oe), .conv_start(conv_start));

  function automatic logic [7:0] exp_byte(input logic cm, sh, os, input int idx,
                                          input logic [14:0] m, input logic p, o);
    if (cm) begin
      if (idx == 0) return {p, m[14:8]};
      if (idx == 1) return m[7:0];
      return {o, m[14:8]};
    end
    if (sh) return {os ? o : p, m[14:8]};
    return m[7:0];
  endfunction

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic capture(input logic [14:0] m, input logic p, input logic o);
    @(negedge clk); res_mag = m; res_pol = p; res_ovr = o; busy = 1;
    @(negedge clk); busy = 0;
    @(negedge clk);
    m_mag = m; m_pol = p; m_ovr = o; m_pos = 0;
  endtask

  task automatic do_read(input string tag);
    logic [7:0] e;
    @(negedge clk); cs = 1; ce_n = 0; rd_n = 0;
    #1;
    e = exp_byte(cont_mode, sel_high, ovr_sel, m_pos, m_mag, m_pol, m_ovr);
    chk(tag, {db_oe, db_out}, {1'b1, e});
    @(negedge clk); rd_n = 1;
    @(negedge clk);
    if (cont_mode) m_pos = (m_pos + 1) % 3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state, R1 idle bus
    chk("R10 start low", {8'h0, conv_start}, 9'h0);
    chk("R1 idle", {db_oe, db_out}, 9'h0);
    sel_high = 1; do_read("R10 reset data high");
    sel_high = 0; do_read("R10 reset data low");

    // R2 R3 directed
    capture(15'h5A3C, 1, 0);
    sel_high = 0; do_read("R2 low byte");
    sel_high = 1; ovr_sel = 0; do_read("R3 high byte sign");
    ovr_sel = 1; do_read("R3 high byte overrange");
    // R1 deselected reads
    @(negedge clk); cs = 0; ce_n = 0; rd_n = 0; #1;
    chk("R1 cs low", {db_oe, db_out}, 9'h0);
    cs = 1; ce_n = 1; #1;
    chk("R1 ce_n high", {db_oe, db_out}, 9'h0);
    ce_n = 0; rd_n = 1; #1;
    chk("R1 rd_n high", {db_oe, db_out}, 9'h0);

    // R8 demand hold over long idle
    repeat (WINDOW + 50) @(negedge clk);
    sel_high = 0; do_read("R8 held low");
    sel_high = 1; ovr_sel = 0; do_read("R8 held high");

    // R9 start pulse
    @(negedge clk); cs = 1; ce_n = 0; wr_n = 0;
    @(negedge clk); chk("R9 pulse", {8'h0, conv_start}, 9'h1);
    @(negedge clk); chk("R9 held low single", {8'h0, conv_start}, 9'h0);
    wr_n = 1;
    @(negedge clk); cs = 0; wr_n = 0;
    @(negedge clk); chk("R9 deselected", {8'h0, conv_start}, 9'h0);
    wr_n = 1; cs = 1; cont_mode = 1;
    @(negedge clk); wr_n = 0;
    @(negedge clk); chk("R9 continuous", {8'h0, conv_start}, 9'h0);
    wr_n = 1;

    // R4 R5 continuous sequence with selects toggled, wrap
    capture(15'h1234, 0, 1);
    for (int i = 0; i < 7; i++) begin
      sel_high = i[0]; ovr_sel = i[1];
      do_read("R4 R5 sequence");
    end
    // R5 deselected edge ignored
    @(negedge clk); cs = 0; rd_n = 0;
    @(negedge clk); rd_n = 1;
    @(negedge clk); cs = 1;
    do_read("R5 deselected edge ignored");
    // R6 capture rewinds mid-sequence
    capture(15'h7F01, 1, 1);
    do_read("R6 rewind");

    // R7 window
    @(negedge clk); res_mag = 15'h2ABC; res_pol = 1; res_ovr = 0; busy = 1;
    @(negedge clk); busy = 0;
    @(posedge clk);
    m_mag = 15'h2ABC; m_pol = 1; m_ovr = 0; m_pos = 0;
    repeat (WINDOW - 1) @(posedge clk);
    @(negedge clk); cs = 1; ce_n = 0; rd_n = 0; #1;
    chk("R7 last valid clock", {db_oe, db_out}, {1'b1, 1'b1, 7'h2A});
    @(negedge clk); #1;
    chk("R7 expired", {db_oe, db_out}, 9'h100);
    rd_n = 1;
    @(negedge clk);

    // random mix
    for (int k = 0; k < 150; k++) begin
      logic [14:0] m;
      logic p, o;
      m = 15'($urandom);
      p = 1'($urandom);
      o = 1'($urandom);
      if (o) m = {7'h0, 8'($urandom % 191)};
      cont_mode = 1'($urandom);
      capture(m, p, o);
      for (int j = 0; j < 4; j++) begin
        sel_high = 1'($urandom);
        ovr_sel = 1'($urandom);
        do_read(cont_mode ? "R4 random continuous" : "R2 R3 random demand");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule